// File: doc/BRIEF.md
# Limit-Switch Hoist Sequencer

This block sequences a motorised hoist, for example a flag on a pole, between a lower and an upper end of travel. It reads two momentary push buttons (one asks for a raise, one asks for a lower) and two end-of-travel switches. It drives two separate motor enables, one for each direction. All inputs are expected to be synchronised and debounced before they reach the block. The block has a single clock and a synchronous reset.

The controller walks through four steps in a fixed ring. In the first it drives down until the bottom switch closes. In the second it rests at the bottom until a raise request. In the third it drives up until the top switch closes. In the fourth it rests at the top until a lower request, and then it returns to the first step. Each step is held in its own bit of a one-hot register. Each step has exactly one input that lets it advance, and every other input is ignored while that step is active. After reset the hoist always homes downward before it will accept a raise request.

Top module: `hoist_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `step_onehot` reads 4'b0001. This is the drive-down step. `mot_dn` is 1 and `mot_up` is 0.
- R2: In the drive-down step (bit 0), a clock edge with `bot_lim` high moves the sequencer to bottom-idle (bit 1, 4'b0010). A clock edge with `bot_lim` low keeps it in drive-down.
- R3: In bottom-idle, a clock edge with `raise_btn` high moves the sequencer to drive-up (bit 2, 4'b0100). Otherwise it stays in bottom-idle.
- R4: In drive-up, a clock edge with `top_lim` high moves the sequencer to top-idle (bit 3, 4'b1000). Otherwise it stays in drive-up.
- R5: In top-idle, a clock edge with `lower_btn` high returns the sequencer to drive-down (4'b0001). The four-step ring then repeats without limit.
- R6: `mot_dn` is 1 exactly when drive-down is the active step. `mot_up` is 1 exactly when drive-up is the active step. The two are never 1 together.
- R7: Exactly one bit of `step_onehot` is set in every cycle after reset. Entering a step clears the previous step on the same edge.
- R8: Every input other than the advancing input of the active step is ignored. This covers buttons pressed while moving, the opposite button in an idle step, and a limit switch outside its own moving step.
- R9: A button held high for only one clock cycle is enough to cause its transition.
- R10: If `bot_lim` is already high when drive-down is entered, the sequencer leaves drive-down on the very next edge. `mot_dn` is then high for that single cycle only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raise_btn | input | 1 | Momentary raise request |
| lower_btn | input | 1 | Momentary lower request |
| top_lim | input | 1 | Upper end-of-travel switch, high when closed |
| bot_lim | input | 1 | Lower end-of-travel switch, high when closed |
| mot_up | output | 1 | Raise motor enable |
| mot_dn | output | 1 | Lower motor enable |
| step_onehot | output | 4 | Active step: bit 0 drive-down, bit 1 bottom-idle, bit 2 drive-up, bit 3 top-idle |

## Verification
The case that matters most is an advancing input arriving in the same cycle as an input that must be ignored. One example is raise and lower pressed together at bottom-idle. Another is a limit switch that is already closed at the moment its moving step is entered, so that entry and exit conditions meet on back-to-back edges. Directed cycles drive both buttons at once, and drive `lower_btn` and `bot_lim` together at top-idle. Random cycles add many more such overlaps. After every edge, the step vector and both motor enables are compared against a next-step function in the bench that follows the four transition rules.

// File: rtl/hoist_pkg.sv
package hoist_pkg;

    localparam int STEP_COUNT = 4;

    localparam int IDX_DESCEND   = 0;
    localparam int IDX_LOW_WAIT  = 1;
    localparam int IDX_ASCEND    = 2;
    localparam int IDX_HIGH_WAIT = 3;

    typedef logic [STEP_COUNT-1:0] step_vec_t;

    typedef struct packed {
        logic raise_cmd;
        logic lower_cmd;
        logic at_top;
        logic at_bottom;
    } hoist_in_t;

    typedef struct packed {
        logic drive_up;
        logic drive_down;
    } motor_cmd_t;

    function automatic step_vec_t step_bit(input int idx);
        step_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    localparam step_vec_t HOME_STEP = step_bit(IDX_DESCEND);

endpackage

// File: rtl/hoist_cond.sv
module hoist_cond
    import hoist_pkg::*;
(
    input  hoist_in_t pins,
    output step_vec_t exit_ok
);

    always_comb begin
        exit_ok                = '0;
        exit_ok[IDX_DESCEND]   = pins.at_bottom;
        exit_ok[IDX_LOW_WAIT]  = pins.raise_cmd;
        exit_ok[IDX_ASCEND]    = pins.at_top;
        exit_ok[IDX_HIGH_WAIT] = pins.lower_cmd;
    end

endmodule

// File: rtl/hoist_steps.sv
module hoist_steps
    import hoist_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  step_vec_t exit_ok,
    output step_vec_t cur
);

    step_vec_t nxt;

    // Each step holds itself until its own exit condition, and is set by its predecessor.
    for (genvar i = 0; i < STEP_COUNT; i++) begin : g_step
        localparam int PREV = (i + STEP_COUNT - 1) % STEP_COUNT;
        assign nxt[i] = (cur[i] & ~exit_ok[i]) | (cur[PREV] & exit_ok[PREV]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= HOME_STEP;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/hoist_drive.sv
module hoist_drive
    import hoist_pkg::*;
(
    input  step_vec_t  cur,
    output motor_cmd_t cmd
);

    always_comb begin
        cmd.drive_up   = cur[IDX_ASCEND];
        cmd.drive_down = cur[IDX_DESCEND];
    end

endmodule

// File: rtl/hoist_seq.sv
module hoist_seq
    import hoist_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  raise_btn,
    input  logic                  lower_btn,
    input  logic                  top_lim,
    input  logic                  bot_lim,
    output logic                  mot_up,
    output logic                  mot_dn,
    output logic [STEP_COUNT-1:0] step_onehot
);

    hoist_in_t  pins;
    step_vec_t  exit_ok;
    step_vec_t  cur;
    motor_cmd_t cmd;

    always_comb begin
        pins.raise_cmd = raise_btn;
        pins.lower_cmd = lower_btn;
        pins.at_top    = top_lim;
        pins.at_bottom = bot_lim;
    end

    hoist_cond u_cond (
        .pins    (pins),
        .exit_ok (exit_ok)
    );

    hoist_steps u_steps (
        .clk     (clk),
        .rst     (rst),
        .exit_ok (exit_ok),
        .cur     (cur)
    );

    hoist_drive u_drive (
        .cur (cur),
        .cmd (cmd)
    );

    assign mot_up      = cmd.drive_up;
    assign mot_dn      = cmd.drive_down;
    assign step_onehot = cur;

endmodule

// File: rtl/hoist_seq_chk.sv
module hoist_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       raise_btn,
    input logic       lower_btn,
    input logic       top_lim,
    input logic       bot_lim,
    input logic       mot_up,
    input logic       mot_dn,
    input logic [3:0] step_onehot
);

    a_r7_one_step: assert property (@(posedge clk) disable iff (rst)
        $countones(step_onehot) == 1);

    a_r6_motors_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mot_up && mot_dn));

    a_r6_down_only_descending: assert property (@(posedge clk) disable iff (rst)
        mot_dn |-> step_onehot[0]);

    a_r2_bottom_reached: assert property (@(posedge clk) disable iff (rst)
        (step_onehot[0] && bot_lim) |=> (step_onehot == 4'b0010));

    a_r3_raise_taken: assert property (@(posedge clk) disable iff (rst)
        (step_onehot[1] && raise_btn) |=> (step_onehot == 4'b0100));

    a_r4_top_reached: assert property (@(posedge clk) disable iff (rst)
        (step_onehot[2] && top_lim) |=> (step_onehot == 4'b1000));

    a_r5_lower_taken: assert property (@(posedge clk) disable iff (rst)
        (step_onehot[3] && lower_btn) |=> (step_onehot == 4'b0001));

    a_r8_descend_holds: assert property (@(posedge clk) disable iff (rst)
        (step_onehot[0] && !bot_lim) |=> step_onehot[0]);

    a_r8_ascend_holds: assert property (@(posedge clk) disable iff (rst)
        (step_onehot[2] && !top_lim) |=> step_onehot[2]);

endmodule

bind hoist_seq hoist_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .raise_btn   (raise_btn),
    .lower_btn   (lower_btn),
    .top_lim     (top_lim),
    .bot_lim     (bot_lim),
    .mot_up      (mot_up),
    .mot_dn      (mot_dn),
    .step_onehot (step_onehot)
);

// File: tb/hoist_seq_test.sv
`timescale 1ns/1ps
module hoist_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       raise_btn = 1'b0;
    logic       lower_btn = 1'b0;
    logic       top_lim = 1'b0;
    logic       bot_lim = 1'b0;
    logic       mot_up;
    logic       mot_dn;
    logic [3:0] step_onehot;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;
    logic [3:0] exp_step = 4'b0001;

    always #5 clk = ~clk;

    hoist_seq uut (
        .clk         (clk),
        .rst         (rst),
        .raise_btn   (raise_btn),
        .lower_btn   (lower_btn),
        .top_lim     (top_lim),
        .bot_lim     (bot_lim),
        .mot_up      (mot_up),
        .mot_dn      (mot_dn),
        .step_onehot (step_onehot)
    );

    function automatic logic [3:0] model_next(input logic [3:0] s, input logic rb, input logic lb,
                                              input logic tl, input logic bl);
        case (s)
            4'b0001: return bl ? 4'b0010 : s;
            4'b0010: return rb ? 4'b0100 : s;
            4'b0100: return tl ? 4'b1000 : s;
            4'b1000: return lb ? 4'b0001 : s;
            default: return 4'b0001;
        endcase
    endfunction

    function automatic string tag_for(input logic r, input logic [3:0] prev, input logic [3:0] nxt);
        if (r)              return "R1";
        if (prev == nxt)    return "R8";
        case (nxt)
            4'b0010: return "R2";
            4'b0100: return "R3";
            4'b1000: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic check4(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Called at a falling edge; drives inputs, lets one rising edge pass, checks at the next falling edge.
    task automatic run_cycle(input logic r, input logic rb, input logic lb, input logic tl,
                             input logic bl, input string tag);
        logic [3:0] prev;
        string      t;
        rst = r; raise_btn = rb; lower_btn = lb; top_lim = tl; bot_lim = bl;
        @(posedge clk);
        prev = exp_step;
        exp_step = r ? 4'b0001 : model_next(exp_step, rb, lb, tl, bl);
        t = (tag == "") ? tag_for(r, prev, exp_step) : tag;
        @(negedge clk);
        check4({t, " step"}, step_onehot, exp_step);
        check4({t, " motors R6"}, {2'b00, mot_up, mot_dn}, {2'b00, exp_step[2], exp_step[0]});
        check4({t, " one-hot R7"}, 4'($countones(step_onehot)), 4'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        run_cycle(1, 0, 0, 0, 0, "R1 reset");
        run_cycle(1, 1, 1, 1, 1, "R1 reset with inputs");
        // R1: first cycle after release, no advance condition
        run_cycle(0, 1, 1, 1, 0, "R1 first cycle R8");
        run_cycle(0, 0, 0, 0, 0, "R2 hold down");
        run_cycle(0, 0, 0, 0, 1, "R2 bottom reached");
        // R8: wrong inputs at bottom-idle
        run_cycle(0, 0, 1, 1, 1, "R8 bottom-idle ignores");
        // R3 and R9: single-cycle pulse, both buttons together
        run_cycle(0, 1, 1, 0, 1, "R3 R9 raise with lower");
        run_cycle(0, 1, 1, 0, 1, "R8 ascend ignores buttons");
        run_cycle(0, 0, 0, 0, 0, "R8 ascend holds");
        run_cycle(0, 0, 0, 1, 0, "R4 top reached");
        run_cycle(0, 1, 0, 1, 1, "R8 top-idle ignores raise");
        // R5 with R10: lower pressed while bottom switch still closed
        run_cycle(0, 0, 1, 1, 1, "R5 lower pulse");
        run_cycle(0, 0, 0, 0, 1, "R10 immediate exit");
        run_cycle(0, 1, 0, 0, 0, "R3 second lap");
        run_cycle(0, 0, 0, 1, 0, "R4 second lap");
        run_cycle(0, 0, 1, 0, 0, "R5 second lap");
        run_cycle(0, 0, 0, 0, 0, "R2 hold after lap");

        begin
            int unsigned seed_dummy;
            seed_dummy = $urandom(32'd24601);
            for (int k = 0; k < 3000; k++) begin
                logic r, rb, lb, tl, bl;
                r  = ($urandom % 150) == 0;
                rb = ($urandom % 4) == 0;
                lb = ($urandom % 4) == 0;
                tl = ($urandom % 3) == 0;
                bl = ($urandom % 3) == 0;
                run_cycle(r, rb, lb, tl, bl, "");
            end
        end
        finish_run();
    end

endmodule